// File: doc/BRIEF.md
# Nibble-Buffered Synchronous Serial Shifter

This block moves a programmable number of 4-bit nibbles between an on-block nibble buffer and a single serial data line, one bit per serial clock. It generates the serial clock itself by dividing the system clock, drives transmit bits on each falling serial-clock edge and captures receive bits on each rising edge. Within each nibble, bit 0 travels first and bit 3 last. Nibbles are taken from, or stored to, consecutive buffer locations, starting at the lowest one.

Software-side logic loads and reads the buffer through a simple synchronous host port. It then sets the transfer length as two 4-bit count fields, chooses the direction and pulses `start`. `busy` covers the transfer and a one-cycle `done` marks its end. The whole function is gated by a port-routing enable. While that enable is low the block stays idle and leaves the data line undriven.

Top module: `nib_shifter`

## Requirements
- R1: When idle, `sclk_o` rests high. During a nibble, each bit takes one serial-clock period of 2*HALF_DIV system clocks, so consecutive rising edges within a nibble are 2*HALF_DIV cycles apart. Transmit bits change on the falling edge, and `sdata_i` is sampled on the rising edge.
- R2: Bits are ordered least significant first within every nibble, on both transmit and receive: bit 0, then 1, 2, 3.
- R3: The transfer length in nibbles is the 8-bit value {`cnt_hi`,`cnt_lo`}, with `cnt_hi` as the upper four bits. A transfer shifts exactly 4 times that many bits, so a count of 2 gives an 8-bit transfer.
- R4: The buffer occupies host addresses 0x050 to 0x14E, which is 255 nibbles. A transfer uses locations in ascending order starting at 0x050, and a count of 255 ends at 0x14E. The engine's location index never exceeds 254.
- R5: A start with a count of zero raises `done` on the next cycle. It does not raise `busy`, produces no serial-clock edge and leaves `sdata_oe` low.
- R6: A start pulse while idle raises `busy` on the next cycle. `busy` stays high until the last bit of the last nibble has been shifted. It then drops in the same cycle as a single-cycle `done`, and `done` is never high while `busy` is high.
- R7: In receive mode (`dir_rx`=1), each nibble is written to its buffer location in the cycle after its fourth bit is sampled. Locations beyond the count are left unchanged. In transmit mode (`dir_rx`=0), `sdata_oe` is high for the whole transfer.
- R8: While `enable` is low, `start` is ignored, `sdata_oe` is low and `sclk_o` is high. Dropping `enable` during a transfer abandons it without a `done` pulse.
- R9: A `start` pulse while `busy` is high is ignored. The running transfer keeps its original length and direction.
- R10: A host read returns the addressed nibble one cycle after the address is presented. A host write outside 0x050..0x14E changes nothing, and a host read outside that range returns 0. If the engine writes in the same cycle as the host, the engine's write is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Port routed to the serial unit |
| start | input | 1 | Single-cycle transfer request |
| dir_rx | input | 1 | 1 = receive into buffer, 0 = transmit from buffer |
| cnt_hi | input | 4 | Upper four bits of the nibble count |
| cnt_lo | input | 4 | Lower four bits of the nibble count |
| host_we | input | 1 | Host buffer write strobe |
| host_addr | input | 9 | Host nibble address |
| host_wdata | input | 4 | Host write nibble |
| host_rdata | output | 4 | Host read nibble, one cycle latency |
| sdata_i | input | 1 | Serial receive data |
| sclk_o | output | 1 | Serial clock, idles high |
| sdata_o | output | 1 | Serial transmit data |
| sdata_oe | output | 1 | Drive enable for the data line |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The hardest case to reach is the very top of the buffer. Only a full 255-nibble transfer exercises location 0x14E and the largest pointer value. The bench runs that length in both directions and checks the last nibble on the line and in the buffer. The bench also sweeps counts around the nibble-register boundaries (15, 16, 17) and plays a receive pattern distinct from the transmit pattern, driven in step with the block's own falling edges. Mid-transfer restart attempts and disabled starts are injected while the serial monitor is running, so that any stray clock edge is caught.

// File: rtl/nib_shifter_pkg.sv
package nib_shifter_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_LOW,
    ST_HIGH
  } eng_state_e;
endpackage

// File: rtl/nib_halfdiv.sv
module nib_halfdiv #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic first,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign first = run && (cnt_q == '0);
  assign tick  = run && (cnt_q == LAST);
endmodule

// File: rtl/nib_ram.sv
module nib_ram #(
  parameter int DW    = 4,
  parameter int DEPTH = 255,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata_a <= mem[raddr_a];
    rdata_b <= mem[raddr_b];
  end
endmodule

// File: rtl/nib_engine.sv
module nib_engine
  import nib_shifter_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter int CNT_W = 8,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             start,
  input  logic             dir_rx,
  input  logic [CNT_W-1:0] count,
  input  logic [NIB_W-1:0] rd_nib,
  input  logic             sdata_i,
  input  logic             first,
  input  logic             tick,
  output logic             run,
  output logic [IDX_W-1:0] idx,
  output logic             we,
  output logic [NIB_W-1:0] wnib,
  output logic             sclk_o,
  output logic             sdata_o,
  output logic             sdata_oe,
  output logic             busy,
  output logic             done
);
  localparam int BIT_W = (NIB_W > 1) ? $clog2(NIB_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(NIB_W - 1);

  eng_state_e       state_q;
  logic [IDX_W-1:0] ptr_q;
  logic [CNT_W-1:0] left_q;
  logic [BIT_W-1:0] bit_q;
  logic [NIB_W-1:0] shreg_q;
  logic             rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      ptr_q    <= '0;
      left_q   <= '0;
      bit_q    <= '0;
      shreg_q  <= '0;
      rx_q     <= 1'b0;
      sclk_o   <= 1'b1;
      sdata_o  <= 1'b0;
      sdata_oe <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!enable) begin
        state_q  <= ST_IDLE;
        sclk_o   <= 1'b1;
        sdata_o  <= 1'b0;
        sdata_oe <= 1'b0;
        busy     <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            if (start) begin
              rx_q  <= dir_rx;
              ptr_q <= '0;
              if (count == '0) begin
                done <= 1'b1;
              end else begin
                left_q   <= count;
                busy     <= 1'b1;
                sdata_oe <= !dir_rx;
                state_q  <= ST_FETCH;
              end
            end
          end
          ST_FETCH: state_q <= ST_LOAD;
          ST_LOAD: begin
            shreg_q <= rd_nib;
            sdata_o <= rx_q ? 1'b0 : rd_nib[0];
            sclk_o  <= 1'b0;
            bit_q   <= '0;
            state_q <= ST_LOW;
          end
          ST_LOW: begin
            if (tick) begin
              sclk_o  <= 1'b1;
              shreg_q <= {sdata_i, shreg_q[NIB_W-1:1]};
              state_q <= ST_HIGH;
            end
          end
          ST_HIGH: begin
            if (tick) begin
              if (bit_q == LAST_BIT) begin
                if (left_q == CNT_W'(1)) begin
                  busy     <= 1'b0;
                  done     <= 1'b1;
                  sdata_oe <= 1'b0;
                  sdata_o  <= 1'b0;
                  state_q  <= ST_IDLE;
                end else begin
                  ptr_q   <= ptr_q + 1'b1;
                  left_q  <= left_q - 1'b1;
                  state_q <= ST_FETCH;
                end
              end else begin
                bit_q   <= bit_q + 1'b1;
                sclk_o  <= 1'b0;
                sdata_o <= rx_q ? 1'b0 : shreg_q[0];
                state_q <= ST_LOW;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign run  = (state_q == ST_LOW) || (state_q == ST_HIGH);
  assign idx  = ptr_q;
  assign we   = enable && rx_q && (state_q == ST_HIGH) && first && (bit_q == LAST_BIT);
  assign wnib = shreg_q;
endmodule

// File: rtl/nib_shifter.sv
module nib_shifter #(
  parameter int             NIB_W     = 4,
  parameter int             ADDR_W    = 9,
  parameter logic [8:0]     BASE_ADDR = 9'h050,
  parameter int             DEPTH     = 255,
  parameter int             HALF_DIV  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              start,
  input  logic              dir_rx,
  input  logic [NIB_W-1:0]  cnt_hi,
  input  logic [NIB_W-1:0]  cnt_lo,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [NIB_W-1:0]  host_wdata,
  output logic [NIB_W-1:0]  host_rdata,
  input  logic              sdata_i,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              sdata_oe,
  output logic              busy,
  output logic              done
);
  localparam int CNT_W = 2 * NIB_W;
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(BASE_ADDR + DEPTH - 1);

  logic [CNT_W-1:0]  count;
  logic              run, first, tick;
  logic [IDX_W-1:0]  eng_idx;
  logic              eng_we;
  logic [NIB_W-1:0]  eng_wnib;
  logic [NIB_W-1:0]  eng_rnib;
  logic              host_in;
  logic [ADDR_W-1:0] host_off;
  logic [IDX_W-1:0]  host_idx;
  logic              host_in_q;
  logic [NIB_W-1:0]  host_raw;
  logic              ram_we;
  logic [IDX_W-1:0]  ram_waddr;
  logic [NIB_W-1:0]  ram_wdata;

  assign count    = {cnt_hi, cnt_lo};
  assign host_in  = (host_addr >= LO_ADDR) && (host_addr <= HI_ADDR);
  assign host_off = host_addr - LO_ADDR;
  assign host_idx = host_in ? host_off[IDX_W-1:0] : '0;

  assign ram_we    = eng_we || (host_we && host_in);
  assign ram_waddr = eng_we ? eng_idx : host_idx;
  assign ram_wdata = eng_we ? eng_wnib : host_wdata;

  always_ff @(posedge clk) begin
    if (rst) host_in_q <= 1'b0;
    else     host_in_q <= host_in;
  end

  assign host_rdata = host_in_q ? host_raw : '0;

  nib_halfdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst(rst), .run(run), .first(first), .tick(tick)
  );

  nib_ram #(.DW(NIB_W), .DEPTH(DEPTH), .AW(IDX_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr_a(host_idx), .rdata_a(host_raw),
    .raddr_b(eng_idx), .rdata_b(eng_rnib)
  );

  nib_engine #(.NIB_W(NIB_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_eng (
    .clk(clk), .rst(rst), .enable(enable), .start(start), .dir_rx(dir_rx),
    .count(count), .rd_nib(eng_rnib), .sdata_i(sdata_i), .first(first),
    .tick(tick), .run(run), .idx(eng_idx), .we(eng_we), .wnib(eng_wnib),
    .sclk_o(sclk_o), .sdata_o(sdata_o), .sdata_oe(sdata_oe),
    .busy(busy), .done(done)
  );
endmodule

// File: rtl/nib_shifter_chk.sv
module nib_shifter_chk #(
  parameter int CNT_W = 8,
  parameter int IDX_W = 8,
  parameter int DEPTH = 255
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             start,
  input logic [CNT_W-1:0] count,
  input logic             sclk_o,
  input logic             sdata_o,
  input logic             sdata_oe,
  input logic             busy,
  input logic             done,
  input logic [IDX_W-1:0] eng_idx,
  input logic             eng_we
);
  // R6
  done_excl_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R6
  busy_end_done_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && $past(enable)) |-> done);

  // R4
  idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
    eng_idx <= IDX_W'(DEPTH - 1));

  // R8
  idle_line_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!sdata_oe && sclk_o));

  // R5
  zero_count_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && start && !busy && count == '0) |=> (done && !busy));

  // R1
  idle_clk_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> sclk_o);

  // R1
  tx_hold_high_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && sclk_o && $past(sclk_o)) |-> $stable(sdata_o));

  // R7
  rx_write_in_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    eng_we |-> (busy && !sdata_oe));
endmodule

bind nib_shifter nib_shifter_chk #(.CNT_W(CNT_W), .IDX_W(IDX_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .start(start), .count(count),
  .sclk_o(sclk_o), .sdata_o(sdata_o), .sdata_oe(sdata_oe), .busy(busy),
  .done(done), .eng_idx(eng_idx), .eng_we(eng_we)
);

// File: tb/nib_shifter_bench.sv
module nib_shifter_bench;
  localparam int DEPTH = 255;

  logic       clk = 1'b0;
  logic       rst, enable, start, dir_rx, host_we, sdata_i;
  logic [3:0] cnt_hi, cnt_lo, host_wdata, host_rdata;
  logic [8:0] host_addr;
  logic       sclk_o, sdata_o, sdata_oe, busy, done;

  int n_chk = 0, n_fail = 0;
  int exp_mem [DEPTH];
  int cap [1024];
  time rise_t [1024];
  int cap_n = 0, rx_k = 0, rx_salt = 0;
  bit mon_on = 1'b0;
  int done_cnt = 0;
  bit busy_seen = 1'b0, oe_seen = 1'b0;

  always #5 clk = ~clk;

  nib_shifter u_nib_shifter (
    .clk(clk), .rst(rst), .enable(enable), .start(start), .dir_rx(dir_rx),
    .cnt_hi(cnt_hi), .cnt_lo(cnt_lo), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .sdata_i(sdata_i),
    .sclk_o(sclk_o), .sdata_o(sdata_o), .sdata_oe(sdata_oe),
    .busy(busy), .done(done)
  );

  function automatic int txp(int i);
    return (i * 7 + 3) & 15;
  endfunction

  function automatic int rxp(int n);
    return (n * 11 + 6 + rx_salt) & 15;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge sclk_o) if (mon_on) begin
    cap[cap_n] = int'(sdata_o);
    rise_t[cap_n] = $time;
    cap_n++;
  end

  always @(negedge sclk_o) if (mon_on) begin
    sdata_i = rxp(rx_k / 4)[rx_k % 4];
    rx_k++;
  end

  always @(negedge clk) if (mon_on) begin
    if (done) done_cnt++;
    if (busy) busy_seen = 1'b1;
    if (sdata_oe) oe_seen = 1'b1;
  end

  task automatic host_wr(input int a, input int d);
    @(negedge clk);
    host_addr = 9'(a); host_wdata = 4'(d); host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_rd(input int a, output int d);
    @(negedge clk);
    host_addr = 9'(a);
    @(negedge clk);
    d = int'(host_rdata);
  endtask

  task automatic run_xfer(input bit rx, input int c, input bit restart);
    int n;
    cap_n = 0; rx_k = 0; done_cnt = 0; busy_seen = 0; oe_seen = 0;
    sdata_i = 1'b0;
    mon_on = 1'b1;
    @(negedge clk);
    dir_rx = rx; cnt_hi = 4'(c >> 4); cnt_lo = 4'(c); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 20000) begin
      if (restart && n == 10) begin
        dir_rx = !rx; cnt_hi = 4'h0; cnt_lo = 4'h5; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    repeat (4) @(negedge clk);
    mon_on = 1'b0;
  endtask

  task automatic tx_case(input int c, input bit restart);
    int bad;
    int first_bad;
    run_xfer(1'b0, c, restart);
    // R3
    chk(cap_n == 4 * c, restart ? "R9 length kept" : "R3 bit count", cap_n, 4 * c);
    bad = 0; first_bad = -1;
    for (int k = 0; k < cap_n && k < 4 * c; k++) begin
      if (cap[k] != txp(k / 4)[k % 4]) begin
        bad++;
        if (first_bad < 0) first_bad = k;
      end
    end
    // R2 / R4
    chk(bad == 0, "R2 R4 lsb-first ascending data", first_bad, -1);
    // R6
    chk(done_cnt == 1 && busy_seen && !busy, "R6 handshake", done_cnt, 1);
    // R7
    chk(oe_seen && !sdata_oe, "R7 tx drive enable", int'(oe_seen), 1);
    if (c >= 1) begin
      // R1
      chk(rise_t[1] - rise_t[0] == 40, "R1 serial period", int'(rise_t[1] - rise_t[0]), 40);
    end
  endtask

  task automatic rx_case(input int c, input int salt);
    int bad;
    int v;
    rx_salt = salt;
    run_xfer(1'b1, c, 1'b0);
    chk(done_cnt == 1 && !oe_seen, "R7 rx handshake no drive", done_cnt, 1);
    for (int i = 0; i < c; i++) exp_mem[i] = rxp(i);
    bad = 0;
    for (int i = 0; i < c; i++) begin
      host_rd(16'h50 + i, v);
      if (v != exp_mem[i]) bad++;
    end
    // R2 R7
    chk(bad == 0, "R2 R7 rx nibbles stored", bad, 0);
    if (c < DEPTH) begin
      host_rd(16'h50 + c, v);
      chk(v == exp_mem[c], "R7 beyond count unchanged", v, exp_mem[c]);
    end
  endtask

  initial begin
    int v;
    rst = 1'b1; enable = 1'b1; start = 1'b0; dir_rx = 1'b0; host_we = 1'b0;
    sdata_i = 1'b0; cnt_hi = 4'h0; cnt_lo = 4'h2; host_addr = 9'h050; host_wdata = 4'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && sclk_o && !sdata_oe, "R1 R6 reset state",
        int'({busy, done, sclk_o, sdata_oe}), 2);

    for (int i = 0; i < DEPTH; i++) begin
      host_wr(16'h50 + i, txp(i));
      exp_mem[i] = txp(i);
    end
    host_rd(16'h50, v);
    chk(v == txp(0), "R10 host read 0x050", v, txp(0));
    host_rd(16'h14E, v);
    chk(v == txp(254), "R10 host read 0x14E", v, txp(254));

    // R10 out-of-window accesses
    host_wr(16'h04F, 4'hF);
    host_wr(16'h14F, 4'hF);
    host_rd(16'h050, v);
    chk(v == txp(0), "R10 low guard write ignored", v, txp(0));
    host_rd(16'h14E, v);
    chk(v == txp(254), "R10 high guard write ignored", v, txp(254));
    host_rd(16'h14F, v);
    chk(v == 0, "R10 outside read zero", v, 0);

    // R5 zero count
    run_xfer(1'b0, 0, 1'b0);
    chk(done_cnt == 1 && !busy_seen && cap_n == 0 && !oe_seen, "R5 zero count",
        done_cnt * 10 + cap_n, 10);

    // transmit sweep including nibble-register boundaries and full buffer
    foreach (exp_mem[i]) exp_mem[i] = txp(i);
    tx_case(1, 1'b0);
    tx_case(2, 1'b0);
    tx_case(3, 1'b0);
    tx_case(15, 1'b0);
    tx_case(16, 1'b0);
    tx_case(17, 1'b0);
    tx_case(255, 1'b0);
    // R4 last location on the line
    v = 0;
    for (int b = 0; b < 4; b++) v |= (cap[254 * 4 + b] & 1) << b;
    chk(v == txp(254), "R4 last nibble 0x14E", v, txp(254));

    // R9 restart attempt mid-transfer
    tx_case(3, 1'b1);

    // R8 disabled start
    enable = 1'b0;
    run_xfer(1'b0, 2, 1'b0);
    chk(done_cnt == 0 && !busy_seen && cap_n == 0 && !oe_seen && sclk_o,
        "R8 disabled start ignored", done_cnt + cap_n, 0);
    enable = 1'b1;

    // receive sweep
    rx_case(1, 0);
    rx_case(4, 3);
    rx_case(17, 9);
    rx_case(255, 5);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule